// File: doc/BRIEF.md
# Trap Entry and Return Unit

This unit performs the architectural bookkeeping of a small 32-bit core when an exception is taken and when software returns from its handler. On an exception request it works out the return address, builds a saved copy of the machine-state word with the cause bits merged in, and forms a reduced new state word. It then redirects instruction fetch to a vector formed from a per-code table entry and a programmable base. On a return strobe it reloads fetch address and state from the two save registers.

The fetch redirect, the new state, both save registers, an invalid-vector pulse and a sticky checkstop flag are all registered, so each is visible in the cycle after the clock edge that accepts the request. The 32-entry vector table and the base register are loaded through a plain write port. Instruction decode, translation and the arbitration of pending interrupts lie outside the unit.

Top module: `trap_unit`

## Requirements
- R1: On entry the saved state becomes the current state with mask 0x783F0000 cleared. For code 6 (program) a cause bit is then ORed in, selected by the 2-bit subtype: 0 floating-point enabled gives 0x00100000, 1 illegal gives 0x00080000, 2 privileged gives 0x00040000, 3 trap gives 0x00020000.
- R2: The new state is zero except for two bits. Bit 12 (machine-check enable) is copied from the old state. Bit 0 (little-endian) is set when bit 16 (interrupt little-endian) of the old state is set.
- R3: The saved return address is the instruction address minus 4 for codes 5 (alignment), 6 (program), 7 (FP unavailable) and 10 (vector unavailable). For every other code it is the instruction address.
- R4: Code 1 (machine check) is taken with bit 12 cleared in the new state when bit 12 was 1. When bit 12 was 0 it sets the sticky halt output and causes no redirect. While halted, every exception and return request is ignored.
- R5: A floating-point enabled program exception is dropped, with no output change, when bit 13 (FP available) is 0 or bits 11 and 8 (FP exception modes) are both 0. When taken, bit 0x00010000 is added to the saved state only if bits 11 and 8 differ.
- R6: The redirect address is the table entry for the code ORed with the base register. It appears with a one-cycle redirect pulse in the cycle after the request.
- R7: If the selected table entry is all ones, the request produces a one-cycle invalid-vector pulse instead of a redirect, and leaves the state and save registers unchanged.
- R8: A return redirects to save register 0 with its low 2 bits cleared. The new state is save register 1 outside mask 0x783F0000 and the current state inside it.
- R9: A return strobe in the same cycle as an exception request is ignored.
- R10: After reset all outputs and save registers are zero, every table entry is all ones and the base is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request strobe |
| exc_code | input | 5 | Exception code, also the vector table index |
| prog_sub | input | 2 | Program-exception subtype |
| cur_pc | input | 32 | Address of the current instruction |
| cur_state | input | 32 | Current machine-state word |
| rfi_req | input | 1 | Return-from-interrupt strobe |
| tab_we | input | 1 | Vector table write enable |
| tab_idx | input | 5 | Vector table write index |
| tab_data | input | 32 | Vector table write data |
| base_we | input | 1 | Vector base write enable |
| base_data | input | 32 | Vector base write data |
| redirect_vld | output | 1 | One-cycle fetch redirect pulse, also the state-update strobe |
| redirect_pc | output | 32 | New fetch address |
| state_out | output | 32 | Updated machine-state word |
| save_pc | output | 32 | Save register 0, the return address |
| save_state | output | 32 | Save register 1, the saved state |
| halted | output | 1 | Sticky checkstop flag |
| vec_err | output | 1 | Invalid-vector pulse |

## Verification
State words are driven with every bit of mask 0x783F0000 set, so that a masking slip shows in both the saved and the restored word. Each program subtype and each floating-point mode combination is applied, which separates the cause bits from the silent drop. Addresses with low bits set are used to tell the current-address classes from the next-address classes and to expose the alignment on return. Unloaded table entries, collisions between a return and an exception, and machine checks with enable on and off each test one gating path that the normal flow never reaches.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int WORD_W = 32;
  localparam int CODE_W = 5;
  localparam int SUB_W  = 2;

  localparam logic [WORD_W-1:0] KEEP_MASK = 32'h783F_0000;
  localparam int BIT_LE  = 0;
  localparam int BIT_FE1 = 8;
  localparam int BIT_FE0 = 11;
  localparam int BIT_ME  = 12;
  localparam int BIT_FP  = 13;
  localparam int BIT_ILE = 16;

  localparam logic [CODE_W-1:0] EX_MCHK   = 5'd1;
  localparam logic [CODE_W-1:0] EX_ALIGN  = 5'd5;
  localparam logic [CODE_W-1:0] EX_PROG   = 5'd6;
  localparam logic [CODE_W-1:0] EX_FPOFF  = 5'd7;
  localparam logic [CODE_W-1:0] EX_VECOFF = 5'd10;

  typedef enum logic [SUB_W-1:0] {
    SUB_FPEN  = 2'd0,
    SUB_ILL   = 2'd1,
    SUB_PRIV  = 2'd2,
    SUB_TRAP  = 2'd3
  } prog_sub_e;

  function automatic logic back_up_pc(input logic [CODE_W-1:0] code);
    return (code == EX_ALIGN) || (code == EX_PROG) ||
           (code == EX_FPOFF) || (code == EX_VECOFF);
  endfunction

  function automatic logic fp_is_quiet(input logic [WORD_W-1:0] st);
    return !st[BIT_FP] || (!st[BIT_FE0] && !st[BIT_FE1]);
  endfunction

  function automatic logic [WORD_W-1:0] prog_cause(input prog_sub_e sub,
                                                   input logic [WORD_W-1:0] st);
    logic [WORD_W-1:0] c;
    c = '0;
    case (sub)
      SUB_FPEN: begin
        c = 32'h0010_0000;
        if (st[BIT_FE0] != st[BIT_FE1]) c = c | 32'h0001_0000;
      end
      SUB_ILL:  c = 32'h0008_0000;
      SUB_PRIV: c = 32'h0004_0000;
      default:  c = 32'h0002_0000;
    endcase
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] saved_word(input logic [WORD_W-1:0] st,
                                                   input logic [CODE_W-1:0] code,
                                                   input prog_sub_e sub);
    logic [WORD_W-1:0] w;
    w = st & ~KEEP_MASK;
    if (code == EX_PROG) w = w | prog_cause(sub, st);
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] entry_word(input logic [WORD_W-1:0] st,
                                                   input logic mchk);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_ME] = st[BIT_ME] & ~mchk;
    w[BIT_LE] = st[BIT_ILE];
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] restore_word(input logic [WORD_W-1:0] saved,
                                                     input logic [WORD_W-1:0] st);
    return (saved & ~KEEP_MASK) | (st & KEEP_MASK);
  endfunction
endpackage

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
  parameter int N = 32,
  parameter int W = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          base_we,
  input  logic [W-1:0]  base_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_entry,
  output logic [W-1:0]  rd_base
);
  logic [W-1:0] ent_q [N];
  logic [W-1:0] base_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ent_q[g] <= '1;
      else if (wr_en && wr_idx == IW'(g))  ent_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_data;
  end

  assign rd_entry = ent_q[rd_idx];
  assign rd_base  = base_q;

  assert_base_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> rd_base == $past(base_data));
endmodule

// File: rtl/trap_entry_calc.sv
module trap_entry_calc
  import trap_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [SUB_W-1:0]  sub,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] st,
  input  logic [WORD_W-1:0] vec_entry,
  input  logic [WORD_W-1:0] vec_base,
  output logic              is_mchk,
  output logic              mchk_stop,
  output logic              fp_drop,
  output logic              vec_bad,
  output logic [WORD_W-1:0] ret_pc,
  output logic [WORD_W-1:0] sv_word,
  output logic [WORD_W-1:0] new_word,
  output logic [WORD_W-1:0] target
);
  prog_sub_e sub_e;
  assign sub_e = prog_sub_e'(sub);

  assign is_mchk   = (code == EX_MCHK);
  assign mchk_stop = is_mchk && !st[BIT_ME];
  assign fp_drop   = (code == EX_PROG) && (sub_e == SUB_FPEN) && fp_is_quiet(st);
  assign vec_bad   = &vec_entry;
  assign ret_pc    = back_up_pc(code) ? pc - WORD_W'(4) : pc;
  assign sv_word   = saved_word(st, code, sub_e);
  assign new_word  = entry_word(st, is_mchk);
  assign target    = vec_entry | vec_base;
endmodule

// File: rtl/trap_return_calc.sv
module trap_return_calc
  import trap_pkg::*;
(
  input  logic [WORD_W-1:0] save_pc,
  input  logic [WORD_W-1:0] save_word,
  input  logic [WORD_W-1:0] st,
  output logic [WORD_W-1:0] back_pc,
  output logic [WORD_W-1:0] back_word
);
  assign back_pc   = {save_pc[WORD_W-1:2], 2'b00};
  assign back_word = restore_word(save_word, st);
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_req,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [SUB_W-1:0]    prog_sub,
  input  logic [WORD_W-1:0]   cur_pc,
  input  logic [WORD_W-1:0]   cur_state,
  input  logic                rfi_req,
  input  logic                tab_we,
  input  logic [CODE_W-1:0]   tab_idx,
  input  logic [WORD_W-1:0]   tab_data,
  input  logic                base_we,
  input  logic [WORD_W-1:0]   base_data,
  output logic                redirect_vld,
  output logic [WORD_W-1:0]   redirect_pc,
  output logic [WORD_W-1:0]   state_out,
  output logic [WORD_W-1:0]   save_pc,
  output logic [WORD_W-1:0]   save_state,
  output logic                halted,
  output logic                vec_err
);
  localparam int VEC_N = 1 << CODE_W;

  logic [WORD_W-1:0] vec_entry, vec_base;
  logic              is_mchk, mchk_stop_c, fp_drop_c, vec_bad_c;
  logic [WORD_W-1:0] ent_pc, ent_word, ent_state, ent_target;
  logic [WORD_W-1:0] rtn_pc, rtn_state;

  logic redirect_q, halt_q, vec_err_q;
  logic [WORD_W-1:0] rpc_q, state_q, save_pc_q, save_state_q;

  trap_vec_table #(.N(VEC_N), .W(WORD_W)) tab_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tab_we), .wr_idx(tab_idx), .wr_data(tab_data),
    .base_we(base_we), .base_data(base_data),
    .rd_idx(exc_code), .rd_entry(vec_entry), .rd_base(vec_base)
  );

  trap_entry_calc ent_i (
    .code(exc_code), .sub(prog_sub), .pc(cur_pc), .st(cur_state),
    .vec_entry(vec_entry), .vec_base(vec_base),
    .is_mchk(is_mchk), .mchk_stop(mchk_stop_c), .fp_drop(fp_drop_c),
    .vec_bad(vec_bad_c), .ret_pc(ent_pc), .sv_word(ent_word),
    .new_word(ent_state), .target(ent_target)
  );

  trap_return_calc rtn_i (
    .save_pc(save_pc_q), .save_word(save_state_q), .st(cur_state),
    .back_pc(rtn_pc), .back_word(rtn_state)
  );

  // Named events for the assertions
  logic exc_ok, stop_ev, drop_ev, bad_ev, take_ev, rfi_ev;
  assign exc_ok  = exc_req && !halt_q;
  assign stop_ev = exc_ok && mchk_stop_c;
  assign drop_ev = exc_ok && !mchk_stop_c && fp_drop_c;
  assign bad_ev  = exc_ok && !mchk_stop_c && !fp_drop_c && vec_bad_c;
  assign take_ev = exc_ok && !mchk_stop_c && !fp_drop_c && !vec_bad_c;
  assign rfi_ev  = rfi_req && !exc_req && !halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q   <= 1'b0;
      vec_err_q    <= 1'b0;
      halt_q       <= 1'b0;
      rpc_q        <= '0;
      state_q      <= '0;
      save_pc_q    <= '0;
      save_state_q <= '0;
    end else begin
      redirect_q <= take_ev || rfi_ev;
      vec_err_q  <= bad_ev;
      if (stop_ev) halt_q <= 1'b1;
      if (take_ev) begin
        rpc_q        <= ent_target;
        state_q      <= ent_state;
        save_pc_q    <= ent_pc;
        save_state_q <= ent_word;
      end else if (rfi_ev) begin
        rpc_q   <= rtn_pc;
        state_q <= rtn_state;
      end
    end
  end

  assign redirect_vld = redirect_q;
  assign redirect_pc  = rpc_q;
  assign state_out    = state_q;
  assign save_pc      = save_pc_q;
  assign save_state   = save_state_q;
  assign halted       = halt_q;
  assign vec_err      = vec_err_q;

  assert_halt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_no_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !redirect_vld && !vec_err);
  assert_mchk_clears_me_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ev && is_mchk) |=> !state_out[BIT_ME]);
  assert_fp_drop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> !redirect_vld && $stable(save_state) && $stable(state_out));
  assert_bad_vec_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_err && redirect_vld));
  assert_bad_vec_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ev |=> $stable(save_pc) && $stable(save_state));
  assert_rfi_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_ev |=> redirect_pc[1:0] == 2'b00 && $stable(save_pc));
  assert_collide_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && rfi_req && !take_ev) |=> !redirect_vld);
endmodule

// File: tb/trap_unit_tb.sv
`timescale 1ns/1ps
module trap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0, rfi_req = 1'b0, tab_we = 1'b0, base_we = 1'b0;
  logic [4:0]  exc_code = '0, tab_idx = '0;
  logic [1:0]  prog_sub = '0;
  logic [31:0] cur_pc = '0, cur_state = '0, tab_data = '0, base_data = '0;
  logic        redirect_vld, halted, vec_err;
  logic [31:0] redirect_pc, state_out, save_pc, save_state;

  always #2.5 clk = ~clk;

  trap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .prog_sub(prog_sub), .cur_pc(cur_pc), .cur_state(cur_state),
    .rfi_req(rfi_req), .tab_we(tab_we), .tab_idx(tab_idx), .tab_data(tab_data),
    .base_we(base_we), .base_data(base_data),
    .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .state_out(state_out),
    .save_pc(save_pc), .save_state(save_state), .halted(halted), .vec_err(vec_err)
  );

  int errors = 0, checks = 0;
  string req_tag = "R10";
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // Behavioural reference model
  logic [31:0] m_tab [32];
  logic [31:0] m_base, m_rpc, m_state, m_spc, m_sst;
  logic        m_vld, m_halt, m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_tab[i] = 32'hFFFF_FFFF;
      m_base = 0; m_rpc = 0; m_state = 0; m_spc = 0; m_sst = 0;
      m_vld = 0; m_halt = 0; m_err = 0;
    end else begin
      m_vld = 0; m_err = 0;
      if (exc_req && !m_halt) begin
        int c;
        c = int'(exc_code);
        if (c == 1 && cur_state[12] == 1'b0) m_halt = 1;
        else if (c == 6 && prog_sub == 2'd0 &&
                 (cur_state[13] == 1'b0 || (cur_state[11] == 1'b0 && cur_state[8] == 1'b0))) begin
          // dropped
        end else if (m_tab[c] == 32'hFFFF_FFFF) m_err = 1;
        else begin
          logic [31:0] s, ns;
          m_spc = (c == 5 || c == 6 || c == 7 || c == 10) ? cur_pc - 4 : cur_pc;
          s = cur_state & 32'h87C0_FFFF;
          if (c == 6) begin
            if (prog_sub == 2'd0) s = s | 32'h0010_0000 | ((cur_state[11] ^ cur_state[8]) ? 32'h0001_0000 : 0);
            else if (prog_sub == 2'd1) s = s | 32'h0008_0000;
            else if (prog_sub == 2'd2) s = s | 32'h0004_0000;
            else s = s | 32'h0002_0000;
          end
          m_sst = s;
          ns = 0;
          if (cur_state[12] && c != 1) ns = ns | 32'h1000;
          if (cur_state[16]) ns = ns | 32'h1;
          m_state = ns;
          m_rpc = m_tab[c] | m_base;
          m_vld = 1;
        end
      end else if (rfi_req && !exc_req && !m_halt) begin
        m_rpc = m_spc & 32'hFFFF_FFFC;
        m_state = (m_sst & 32'h87C0_FFFF) | (cur_state & 32'h783F_0000);
        m_vld = 1;
      end
      if (tab_we) m_tab[tab_idx] = tab_data;
      if (base_we) m_base = base_data;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      cmp("redirect_vld", 32'(redirect_vld), 32'(m_vld));
      cmp("redirect_pc", redirect_pc, m_rpc);
      cmp("state_out", state_out, m_state);
      cmp("save_pc", save_pc, m_spc);
      cmp("save_state", save_state, m_sst);
      cmp("halted", 32'(halted), 32'(m_halt));
      cmp("vec_err", 32'(vec_err), 32'(m_err));
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    exc_req = 0; rfi_req = 0; tab_we = 0; base_we = 0;
    tick();
  endtask

  task automatic do_exc(logic [4:0] c, logic [1:0] s, logic [31:0] pc, logic [31:0] st);
    exc_req = 1; exc_code = c; prog_sub = s; cur_pc = pc; cur_state = st;
    tick();
    idle();
  endtask

  task automatic do_rfi(logic [31:0] st);
    rfi_req = 1; cur_state = st;
    tick();
    idle();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk_on = 1;
    // R10: reset values and all-ones table
    req_tag = "R10";
    idle();
    do_exc(5'd2, 2'd0, 32'h100, 32'h1000);
    // R6: load table and base
    req_tag = "R6";
    for (int i = 1; i < 12; i++) begin
      tab_we = 1; tab_idx = 5'(i); tab_data = 32'h100 * i;
      tick();
    end
    tab_we = 0; base_we = 1; base_data = 32'hFFF0_0000;
    tick();
    idle();
    // R1 R2 R3: next-address class, ILE and ME set, masked bits set
    req_tag = "R1_R2_R3";
    do_exc(5'd2, 2'd0, 32'h0000_4000, 32'h783F_1F01 | 32'h8000_0004);
    do_exc(5'd9, 2'd0, 32'h0000_4100, 32'h0000_0FFF);
    // R3: current-address classes
    req_tag = "R3";
    do_exc(5'd5, 2'd0, 32'h0000_5004, 32'hFFFF_FFFF);
    do_exc(5'd7, 2'd0, 32'h0000_5008, 32'h0000_1000);
    do_exc(5'd10, 2'd0, 32'h0000_500C, 32'h0001_0000);
    // R1: program subtypes
    req_tag = "R1";
    do_exc(5'd6, 2'd1, 32'h6000, 32'h783F_0000);
    do_exc(5'd6, 2'd2, 32'h6004, 32'h0000_1000);
    do_exc(5'd6, 2'd3, 32'h6008, 32'h1234_5678);
    // R5: floating-point enabled drops and mode combinations
    req_tag = "R5";
    do_exc(5'd6, 2'd0, 32'h7000, 32'h0000_2000);
    do_exc(5'd6, 2'd0, 32'h7004, 32'h0000_0900);
    do_exc(5'd6, 2'd0, 32'h7008, 32'h0000_2900);
    do_exc(5'd6, 2'd0, 32'h700C, 32'h0000_2800);
    do_exc(5'd6, 2'd0, 32'h7010, 32'h0000_2100);
    // R7: unloaded entry
    req_tag = "R7";
    do_exc(5'd12, 2'd0, 32'h8000, 32'h0000_1000);
    tab_we = 1; tab_idx = 5'd13; tab_data = 32'hFFFF_FFFF;
    tick();
    do_exc(5'd13, 2'd0, 32'h8004, 32'h0);
    // R8: return with unaligned save and masked-bit merge
    req_tag = "R8";
    do_exc(5'd8, 2'd0, 32'h0000_9003, 32'h783F_1003);
    do_rfi(32'h0000_0000);
    do_rfi(32'h783F_0000);
    // R9: collision
    req_tag = "R9";
    exc_req = 1; rfi_req = 1; exc_code = 5'd4; cur_pc = 32'hA000; cur_state = 32'h1000;
    tick();
    exc_req = 1; rfi_req = 1; exc_code = 5'd6; prog_sub = 2'd0; cur_state = 32'h0;
    tick();
    idle();
    // R4: machine check
    req_tag = "R4";
    do_exc(5'd1, 2'd0, 32'hB000, 32'h0001_1000);
    do_exc(5'd1, 2'd0, 32'hB004, 32'h0000_0000);
    do_exc(5'd3, 2'd0, 32'hB008, 32'h0000_1000);
    do_rfi(32'h0);
    idle();
    finish_run();
  end
endmodule